// File: doc/BRIEF.md
# Iterative SHA-1 Compression Engine

The engine applies the SHA-1 compression function to 512-bit message blocks. It holds the 160-bit chaining value between blocks. A host moves data over a single 32-bit bidirectional bus and uses two command inputs: one loads a block and one reads the digest. A single ready output says when the engine is idle. While ready is high, the host owns the bus. The engine drives the bus only while it returns the digest, and ready is low during that time. Padding the message and splitting it into blocks are left to the host.

After a block command, the engine takes sixteen words from the bus and then runs one round per clock for 80 rounds. It draws each schedule word from a rolling sixteen-word store that refills itself as the rounds run. It then adds the working variables into the chaining value and goes back to idle. Blocks loaded one after another chain from the updated value. Only reset puts the initial constants back.

Top module: `sha1_engine`

## Requirements
- R1: After reset, ready is high and the chaining value holds 67452301, EFCDAB89, 98BADCFE, 10325476, C3D2E1F0 (hex), word 0 first.
- R2: When `blk_req` is high at a clock edge while ready is high, the engine captures message words 0 to 15 from the bus at the next sixteen rising edges, in order. Word 0 is the most significant word of the block.
- R3: Round t (0 to 79) computes rotl5(a)+f+e+k+w[t] modulo 2^32 and shifts the working variables, with c taking rotl30(b). Rounds 0-19 use choose with k=5A827999. Rounds 20-39 and 60-79 use parity with k=6ED9EBA1 and CA62C1D6 respectively. Rounds 40-59 use majority with k=8F1BBCDC. The one-block message "abc" yields a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R4: Ready is low for exactly 97 cycles after an accepted block command: 16 load cycles, 80 round cycles and 1 chaining cycle. It is high again on the next cycle.
- R5: When `hash_req` is high at an edge while ready is high, the engine drives chaining words 0 to 4 on the five following cycles and keeps ready low during them. Ready is high after them. The engine never drives the bus while ready is high.
- R6: Each block adds its working variables into the chaining value modulo 2^32, so a second block starts from the updated value. The chaining value changes at no other time except reset.
- R7: Commands that arrive while ready is low have no effect on the digest or on the ready timing.
- R8: When both commands are high at an edge while ready is high, the hash read is performed and no block load starts.
- R9: Reset in the middle of a block load or of the rounds returns ready high and restores the initial chaining value.
- R10: A hash read leaves the chaining value unchanged, so two reads in a row return the same five words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_req | input | 1 | Start a sixteen-word block load |
| hash_req | input | 1 | Start a five-word digest read |
| rdy | output | 1 | Idle and bus in input direction |
| dbus | inout | 32 | Shared data bus |

## Verification
The main risk is the cycle alignment of the bus. If the load counter is off by one, the words shift and the known "abc" digest comes out wrong. If the read starts a cycle early or late, the bench sees the wrong word in each slot. The ready-low window is counted cycle by cycle, so a round count or chaining step that is one too short or too long shows up as 96 or 98 cycles. Commands are poked during the rounds, both commands are raised together, and a reset is applied halfway through a load. An engine that took busy-time commands would corrupt the digest or the timing. Wrong arbitration would start a load instead of a read. A reset that left state behind would return a non-initial digest. A second block is checked against a bench model, so a missing or wrong chaining addition shows up in the next digest.

// File: rtl/sha1_engine.sv
module sha1_engine #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_req,
  input  logic          hash_req,
  output logic          rdy,
  inout  wire  [DW-1:0] dbus
);
  localparam int NWORDS  = 16;
  localparam int NROUNDS = 80;
  localparam int NHASH   = 5;
  localparam int CW      = $clog2(NROUNDS);
  localparam logic [CW-1:0] LAST_LD  = CW'(NWORDS - 1);
  localparam logic [CW-1:0] LAST_RND = CW'(NROUNDS - 1);
  localparam logic [CW-1:0] LAST_OUT = CW'(NHASH - 1);
  localparam logic [NHASH*DW-1:0] H_INIT =
    160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RND, S_FIN, S_OUT} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  hv [NHASH];
  logic [DW-1:0]  va, vb, vc, vd, ve;
  logic [DW-1:0]  ws [NWORDS];
  logic [DW-1:0]  fv, kv, tmp, wnew, out_word;
  logic           oe;

  function automatic logic [DW-1:0] rotl(input logic [DW-1:0] x, input int n);
    return (x << n) | (x >> (DW - n));
  endfunction

  assign rdy  = (st == S_IDLE);
  assign oe   = (st == S_OUT);
  assign dbus = oe ? out_word : {DW{1'bz}};

  always_comb begin
    if (cnt < CW'(20)) begin
      fv = (vb & vc) | (~vb & vd);
      kv = 32'h5A827999;
    end else if (cnt < CW'(40)) begin
      fv = vb ^ vc ^ vd;
      kv = 32'h6ED9EBA1;
    end else if (cnt < CW'(60)) begin
      fv = (vb & vc) | (vb & vd) | (vc & vd);
      kv = 32'h8F1BBCDC;
    end else begin
      fv = vb ^ vc ^ vd;
      kv = 32'hCA62C1D6;
    end
  end

  assign tmp  = rotl(va, 5) + fv + ve + kv + ws[0];
  assign wnew = rotl(ws[13] ^ ws[8] ^ ws[2] ^ ws[0], 1);

  always_comb begin
    case (cnt[2:0])
      3'd0:    out_word = hv[0];
      3'd1:    out_word = hv[1];
      3'd2:    out_word = hv[2];
      3'd3:    out_word = hv[3];
      default: out_word = hv[4];
    endcase
  end

  always_ff @(posedge clk) begin
    if (st == S_LOAD || st == S_RND) begin
      for (int i = 0; i < NWORDS - 1; i++) ws[i] <= ws[i+1];
      ws[NWORDS-1] <= (st == S_LOAD) ? dbus : wnew;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      for (int i = 0; i < NHASH; i++) hv[i] <= H_INIT[(NHASH-1-i)*DW +: DW];
      {va, vb, vc, vd, ve} <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (hash_req) st <= S_OUT;
          else if (blk_req) begin
            st <= S_LOAD;
            {va, vb, vc, vd, ve} <= {hv[0], hv[1], hv[2], hv[3], hv[4]};
          end
        end
        S_LOAD: begin
          cnt <= (cnt == LAST_LD) ? '0 : cnt + 1'b1;
          if (cnt == LAST_LD) st <= S_RND;
        end
        S_RND: begin
          {va, vb, vc, vd, ve} <= {tmp, va, rotl(vb, 30), vc, vd};
          cnt <= cnt + 1'b1;
          if (cnt == LAST_RND) st <= S_FIN;
        end
        S_FIN: begin
          hv[0] <= hv[0] + va;
          hv[1] <= hv[1] + vb;
          hv[2] <= hv[2] + vc;
          hv[3] <= hv[3] + vd;
          hv[4] <= hv[4] + ve;
          st    <= S_IDLE;
        end
        S_OUT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_OUT) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [NHASH*DW-1:0] hcat;
  assign hcat = {hv[0], hv[1], hv[2], hv[3], hv[4]};

  // R4
  blk_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && blk_req && !hash_req) |=> (!rdy && !oe));
  // R4
  ready_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RND && cnt == LAST_RND) |=> ##1 rdy);
  // R5
  hash_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && hash_req) |=> oe);
  // R5
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> !oe);
  // R8
  hash_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && hash_req && blk_req) |=> (st == S_OUT));
  // R6
  chain_only_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_FIN) |=> $stable(hcat));
endmodule

// File: tb/sha1_engine_tb.sv
module sha1_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_req = 1'b0, hash_req = 1'b0;
  logic rdy;
  logic tb_oe = 1'b0;
  logic [31:0] tb_word = '0;
  tri [31:0] dbus;
  assign dbus = tb_oe ? tb_word : 32'hz;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] mh [5];
  logic [31:0] msg [16];
  localparam logic [31:0] INIT [5] =
    '{32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};

  sha1_engine u_dut (.clk(clk), .rst_n(rst_n), .blk_req(blk_req),
                     .hash_req(hash_req), .rdy(rdy), .dbus(dbus));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  task automatic model_block();
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 80; i++)
      w[i] = (i < 16) ? msg[i] : rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = mh[0]; b = mh[1]; c = mh[2]; d = mh[3]; e = mh[4];
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    mh[0] += a; mh[1] += b; mh[2] += c; mh[3] += d; mh[4] += e;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; blk_req = 0; hash_req = 0; tb_oe = 0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 5; i++) mh[i] = INIT[i];
  endtask

  // Loads msg; poke=1 pulses commands during the busy window
  task automatic load_block(input bit poke);
    int low = 0;
    @(negedge clk); blk_req = 1'b1;
    @(negedge clk); blk_req = 1'b0; tb_oe = 1'b1;
    for (int j = 0; j < 16; j++) begin
      tb_word = msg[j];
      if (!rdy) low++;
      @(negedge clk);
    end
    tb_oe = 1'b0;
    while (!rdy && low < 200) begin
      low++;
      if (poke) begin
        hash_req = (low == 40);
        blk_req  = (low == 60);
      end
      @(negedge clk);
    end
    hash_req = 0; blk_req = 0;
    chk(low == 97, poke ? "R7 busy window with pokes" : "R4 busy window", low, 97);
    model_block();
  endtask

  task automatic read_hash(input string req, input bit both);
    @(negedge clk); hash_req = 1'b1; blk_req = both;
    @(negedge clk); hash_req = 1'b0; blk_req = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(dbus === mh[k] && !rdy, req, dbus, mh[k]);
      @(negedge clk);
    end
    chk(rdy === 1'b1, {req, " ready after read"}, 32'(rdy), 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk(rdy === 1'b1, "R1 ready after reset", 32'(rdy), 1);
    read_hash("R1 initial chaining", 0);
  endtask

  task automatic t_abc();
    logic [31:0] gold [5] =
      '{32'ha9993e36, 32'h4706816a, 32'hba3e2571, 32'h7850c26c, 32'h9cd0d89d};
    do_reset();
    for (int i = 0; i < 16; i++) msg[i] = '0;
    msg[0] = 32'h61626380; msg[15] = 32'h00000018;
    load_block(0);
    for (int i = 0; i < 5; i++) chk(mh[i] === gold[i], "R3 model vs known digest", mh[i], gold[i]);
    read_hash("R2 R3 abc digest", 0);
  endtask

  task automatic t_chain();
    for (int i = 0; i < 16; i++) msg[i] = 32'h9E3779B9 * (i + 1) ^ 32'hA5A5A5A5;
    load_block(0);
    read_hash("R6 second block chains", 0);
    read_hash("R10 repeat read", 0);
  endtask

  task automatic t_ignore();
    for (int i = 0; i < 16; i++) msg[i] = (i % 2 == 0) ? 32'hFFFFFFFF : 32'h00000000;
    load_block(1);
    read_hash("R7 digest after pokes", 0);
  endtask

  task automatic t_both();
    read_hash("R8 both commands read", 1);
    read_hash("R8 no load started", 0);
  endtask

  task automatic t_abort();
    @(negedge clk); blk_req = 1'b1;
    @(negedge clk); blk_req = 1'b0; tb_oe = 1'b1; tb_word = 32'h12345678;
    repeat (8) @(negedge clk);
    tb_oe = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(rdy === 1'b1, "R9 ready during reset", 32'(rdy), 1);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) mh[i] = INIT[i];
    read_hash("R9 init after abort", 0);
  endtask

  initial begin
    t_reset();
    t_abc();
    t_chain();
    t_ignore();
    t_both();
    t_abort();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule